// File: doc/BRIEF.md
# Fast-Path Fault Shutdown Controller

This block handles shutdown for one gate-drive leg whose shutdown input and fault output share a single active-low pin. It takes an over-current flag, already synchronized and raised when the shunt voltage passes a comparator reference of about half a volt. It also takes two digitized views of the shared pin: one says the pin is above its upper logic threshold, the other says it is below its lower threshold. From these it produces a gate-disable level for the downstream interlock logic, an enable for the open-drain transistor that pulls the shared pin low, and a fault status for a supervising controller.

An over-current trip disables the gates on the next clock through a dedicated path that ignores the pin level. The same trip latches the pull-down on. The pull-down stays on until the pin is seen below its lower threshold, which stretches the real disable time past the external RC constant. After release the pin recovers through the external network, and the gates come back only when the pin has crossed the upper threshold again. Pulling the pin low from outside also keeps the gates off, and that case neither raises a fault nor drives the pull-down. The pin flags pass through a synchronizer whose depth is a parameter. The over-current flag has exactly one register, so the fast path stays short.

Top module: `tripsd_ctrl`

## Requirements
- R1: While reset is asserted, and after it until the synchronized pin reads above the upper threshold, gate_off_o is 1 and both pulldown_en_o and fault_o are 0.
- R2: oc_trip_i sampled high at a clock edge sets gate_off_o to 1 right after that edge, whatever the pin flags are.
- R3: An over-current trip sets pulldown_en_o to 1 in the same cycle that gate_off_o rises.
- R4: Once set, pulldown_en_o stays 1 until the synchronized lower-threshold flag is seen with no trip present. It drops one clock after that.
- R5: With no trip present, a pin that reads not above the upper threshold holds gate_off_o at 1 while pulldown_en_o and fault_o stay 0.
- R6: After a fault, and after an external shutdown, gate_off_o returns to 0 one clock after the synchronized upper-threshold flag is seen high with no trip present.
- R7: A trip during recovery (pull-down released, pin still below the upper threshold) sets pulldown_en_o again and restarts the hold phase.
- R8: fault_o is 1 from the clock after a trip until gate_off_o returns to 0, and it is 0 whenever the gates are enabled.
- R9: While oc_trip_i stays high, pulldown_en_o stays 1 even when the pin reads below the lower threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oc_trip_i | input | 1 | Synchronized over-current comparator flag, 1 = fault |
| pin_above_hi_i | input | 1 | Shared pin above its upper threshold (1 = released) |
| pin_below_lo_i | input | 1 | Shared pin below its lower threshold |
| gate_off_o | output | 1 | 1 = both gate outputs of the leg disabled |
| pulldown_en_o | output | 1 | 1 = open-drain pull-down on the shared pin active |
| fault_o | output | 1 | Fault status, raised from a trip until the gates are re-enabled |

## Verification
The bench builds the block with the default pin synchronizer depth of two. This makes the pin flags lag the trip path by a visible extra cycle, so the test can show that a trip acts before any pin change could. The two-cycle lag also gives room for vectors in which the pin crosses its lower threshold while the trip is still held. The recovery sequence can then be interrupted by a fresh trip before the upper-threshold flag has reached the state machine.

// File: rtl/tripsd_pkg.sv
package tripsd_pkg;

   // Leg shutdown phases
   typedef enum logic [1:0] {
      SD_WAIT  = 2'd0,   // no fault, waiting for pin to be released
      SD_RUN   = 2'd1,   // gates allowed
      SD_HOLD  = 2'd2,   // fault: pull-down latched on
      SD_RECOV = 2'd3    // fault: pull-down released, pin recovering
   } sd_state_e;

   localparam int unsigned PIN_FLAG_W = 2;   // {below_lo, above_hi}
   localparam int unsigned PIN_HI_BIT = 0;
   localparam int unsigned PIN_LO_BIT = 1;

   function automatic logic in_fault(sd_state_e s);
      return (s == SD_HOLD) || (s == SD_RECOV);
   endfunction

endpackage

// File: rtl/tripsd_sync.sv
module tripsd_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[LAST];

endmodule

// File: rtl/tripsd_fsm.sv
module tripsd_fsm
   import tripsd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      trip_q_i,
   input  logic      hi_q_i,
   input  logic      lo_q_i,
   output sd_state_e state_o
);

   sd_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (trip_q_i) begin
         state_d = SD_HOLD;              // any trip (re)starts the hold phase
      end else begin
         unique case (state_q)
            SD_WAIT:  if (hi_q_i)  state_d = SD_RUN;
            SD_RUN:   if (!hi_q_i) state_d = SD_WAIT;
            SD_HOLD:  if (lo_q_i)  state_d = SD_RECOV;
            SD_RECOV: if (hi_q_i)  state_d = SD_RUN;
            default:               state_d = SD_WAIT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SD_WAIT;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/tripsd_outs.sv
module tripsd_outs
   import tripsd_pkg::*;
(
   input  sd_state_e state_i,
   input  logic      trip_q_i,
   input  logic      hi_q_i,
   output logic      gate_off_o,
   output logic      pulldown_en_o,
   output logic      fault_o
);

   // Fast path: the registered trip acts without waiting for the state.
   always_comb begin
      gate_off_o    = trip_q_i | ~hi_q_i | (state_i != SD_RUN);
      pulldown_en_o = trip_q_i | (state_i == SD_HOLD);
      fault_o       = trip_q_i | in_fault(state_i);
   end

endmodule

// File: rtl/tripsd_ctrl.sv
module tripsd_ctrl
   import tripsd_pkg::*;
#(
   parameter int unsigned PIN_SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oc_trip_i,
   input  logic pin_above_hi_i,
   input  logic pin_below_lo_i,
   output logic gate_off_o,
   output logic pulldown_en_o,
   output logic fault_o
);

   localparam int unsigned TRIP_STAGES = 1;

   generate
      if (PIN_SYNC_STAGES < 1 || PIN_SYNC_STAGES > 4) begin : g_bad_depth
         $error("tripsd_ctrl: PIN_SYNC_STAGES must be 1..4");
      end
   endgenerate

   logic                  trip_q;
   logic [PIN_FLAG_W-1:0] pin_raw, pin_q;
   sd_state_e             state;

   assign pin_raw[PIN_HI_BIT] = pin_above_hi_i;
   assign pin_raw[PIN_LO_BIT] = pin_below_lo_i;

   tripsd_sync #(.WIDTH(1), .STAGES(TRIP_STAGES), .RST_VAL(1'b0)) i_trip_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (oc_trip_i),
      .q_o   (trip_q)
   );

   tripsd_sync #(.WIDTH(PIN_FLAG_W), .STAGES(PIN_SYNC_STAGES), .RST_VAL('0)) i_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_raw),
      .q_o   (pin_q)
   );

   tripsd_fsm i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .trip_q_i (trip_q),
      .hi_q_i   (pin_q[PIN_HI_BIT]),
      .lo_q_i   (pin_q[PIN_LO_BIT]),
      .state_o  (state)
   );

   tripsd_outs i_outs (
      .state_i       (state),
      .trip_q_i      (trip_q),
      .hi_q_i        (pin_q[PIN_HI_BIT]),
      .gate_off_o    (gate_off_o),
      .pulldown_en_o (pulldown_en_o),
      .fault_o       (fault_o)
   );

endmodule

// File: rtl/tripsd_checker.sv
module tripsd_checker (
   input logic clk,
   input logic rst_n,
   input logic oc_trip_i,
   input logic gate_off_o,
   input logic pulldown_en_o,
   input logic fault_o
);

   // R1: outputs held safe during reset
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_safe_r1: assert (gate_off_o && !pulldown_en_o && !fault_o)
            else $error("reset state violated");
      end
   end

   p_trip_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      oc_trip_i |=> gate_off_o);

   p_trip_pulldown_r3: assert property (@(posedge clk) disable iff (!rst_n)
      oc_trip_i |=> pulldown_en_o);

   p_pulldown_gates_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pulldown_en_o |-> gate_off_o);

   p_trip_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      oc_trip_i |=> fault_o);

   p_enabled_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_off_o |-> (!fault_o && !pulldown_en_o));

   p_hold_persist_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pulldown_en_o && oc_trip_i) |=> pulldown_en_o);

endmodule

bind tripsd_ctrl tripsd_checker i_tripsd_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .oc_trip_i     (oc_trip_i),
   .gate_off_o    (gate_off_o),
   .pulldown_en_o (pulldown_en_o),
   .fault_o       (fault_o)
);

// File: tb/test_tripsd_ctrl.sv
module test_tripsd_ctrl;

   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC = 38;
   localparam int  WATCHDOG_CYC = 5000;

   // entry: {req[3:0], oc, hi, lo, gate_off, pulldown, fault}
   localparam logic [9:0] VEC [NVEC] = '{
      {4'd1, 3'b010, 3'b100},   // R1 reset wait
      {4'd1, 3'b010, 3'b100},   // R1
      {4'd6, 3'b010, 3'b000},   // R6 gates on
      {4'd6, 3'b010, 3'b000},
      {4'd2, 3'b110, 3'b111},   // R2 trip, next clock
      {4'd3, 3'b000, 3'b111},   // R3 pull-down on
      {4'd4, 3'b000, 3'b111},   // R4 held
      {4'd4, 3'b001, 3'b111},
      {4'd4, 3'b001, 3'b111},
      {4'd4, 3'b001, 3'b101},   // R4 released
      {4'd8, 3'b000, 3'b101},   // R8 status held
      {4'd8, 3'b010, 3'b101},
      {4'd6, 3'b010, 3'b101},
      {4'd6, 3'b010, 3'b000},   // R6 re-enabled
      {4'd5, 3'b000, 3'b000},   // R5 external shutdown
      {4'd5, 3'b000, 3'b100},
      {4'd5, 3'b001, 3'b100},
      {4'd5, 3'b001, 3'b100},
      {4'd5, 3'b010, 3'b100},
      {4'd5, 3'b010, 3'b100},
      {4'd6, 3'b010, 3'b000},
      {4'd2, 3'b110, 3'b111},   // R2
      {4'd9, 3'b100, 3'b111},   // R9 trip held
      {4'd9, 3'b101, 3'b111},
      {4'd9, 3'b101, 3'b111},
      {4'd9, 3'b101, 3'b111},
      {4'd4, 3'b001, 3'b111},
      {4'd4, 3'b001, 3'b101},
      {4'd8, 3'b000, 3'b101},
      {4'd7, 3'b100, 3'b111},   // R7 retrip in recovery
      {4'd7, 3'b010, 3'b111},
      {4'd7, 3'b010, 3'b111},
      {4'd4, 3'b001, 3'b111},
      {4'd4, 3'b001, 3'b111},
      {4'd4, 3'b001, 3'b101},
      {4'd8, 3'b010, 3'b101},
      {4'd8, 3'b010, 3'b101},
      {4'd6, 3'b010, 3'b000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic oc_trip = 1'b0, pin_hi = 1'b0, pin_lo = 1'b0;
   logic gate_off, pulldown_en, fault;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tripsd_ctrl #(.PIN_SYNC_STAGES(2)) i_tripsd_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .oc_trip_i      (oc_trip),
      .pin_above_hi_i (pin_hi),
      .pin_below_lo_i (pin_lo),
      .gate_off_o     (gate_off),
      .pulldown_en_o  (pulldown_en),
      .fault_o        (fault)
   );

   task automatic check(input int req, input logic [2:0] exp, input string what);
      n_checks++;
      if ({gate_off, pulldown_en, fault} !== exp) begin
         n_errors++;
         $display("FAIL R%0d %s: got gate/pd/flt=%b expected %b",
                  req, what, {gate_off, pulldown_en, fault}, exp);
      end
   endtask

   task automatic drive(input logic [2:0] v);
      {oc_trip, pin_hi, pin_lo} = v;
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(1, 3'b100, "during reset");                // R1
      rst_n = 1'b1;
      // R1: pin low after reset keeps gates off, no fault
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(1, 3'b100, "post-reset pin low");
      end
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: apply at negedge, check at following negedge
      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i][5:3]);
         @(negedge clk);
         check(int'(VEC[i][9:6]), VEC[i][2:0], $sformatf("vector %0d", i));
      end

      // R1: reset taken in the middle of a hold phase clears it
      drive(3'b100);
      @(negedge clk);
      check(3, 3'b111, "trip before reset");
      drive(3'b000);
      rst_n = 1'b0;
      #1;
      check(1, 3'b100, "reset during hold");
      @(negedge clk);
      rst_n = 1'b1;
      // R6: pin released after reset, gates back on third sample
      drive(3'b010);
      @(negedge clk);
      check(1, 3'b100, "release 1");
      @(negedge clk);
      check(1, 3'b100, "release 2");
      @(negedge clk);
      check(6, 3'b000, "release 3");
      // R2: single-cycle trip with pin high
      drive(3'b110);
      @(negedge clk);
      check(2, 3'b111, "short trip");
      drive(3'b010);
      @(negedge clk);
      check(4, 3'b111, "short trip hold");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule